// File: doc/BRIEF.md
# AXI3 Burst-Splitting Read Master

This block turns one local read command into AXI3 read traffic. A command names a start byte address, a total beat count, a transfer size code, a burst type, a transaction ID and two start delays. The block issues the read as a series of address bursts. Each burst is at most 16 beats, because the burst length field is 4 bits wide. It then gathers the returned data beats in order and hands each one on to a local output stream.

Every returned beat has its ID compared with the command's ID. It also has its response code inspected. A mismatch or an error response sets a sticky flag, and the beat is still delivered and counted. The transfer therefore always finishes with exactly the requested number of beats. A one-cycle done pulse marks the end. The address issue and the read-ready assertion each wait for their own programmable number of cycles after the command is taken.

The output stream follows valid/ready rules with no buffering. `out_valid` mirrors `rvalid` while the data phase is open, and `rready` is only raised while `out_ready` is high. A consumer that holds `out_ready` low therefore stalls the read channel directly, and one handshake on the output is one beat accepted on the bus. The command port accepts a new command only while the block is idle. `cmd_beats` must be at least 1.

Top module: `axrd_master`

## Requirements
- R1: `cmd_ready` is high exactly when no transfer is in progress. A command is taken on a rising edge with `cmd_valid` and `cmd_ready` both high, and `cmd_ready` is low from the cycle after that edge until the transfer ends.
- R2: A command of N beats produces ceil(N/16) address bursts. Every burst except the last carries `arlen` = 15, and the last carries `arlen` = N - 16*floor((N-1)/16) - 1.
- R3: Burst b has `araddr` = start + b*(16 << size). Every burst carries `arsize`, `arburst` and `arid` from the command. `arlock`, `arcache`, `arprot` and `arqos` are always zero.
- R4: With an address delay of A, `arvalid` first rises A cycles after the cycle following the accepting edge. With a data delay of D, `rready` is never high before D cycles have passed in the same sense.
- R5: Once `arvalid` is high, it stays high and the burst fields stay stable until an edge with `arready` high.
- R6: During the data phase, `rready` equals `out_ready`, `out_valid` equals `rvalid` and `out_data` equals `rdata`. Exactly N beats are accepted, and `rready` is low once the last one has been taken.
- R7: A beat whose `rid` differs from the command ID is still delivered and counted. It sets the sticky `id_err` in the cycle after its edge, and `id_err` clears on the edge that accepts the next command.
- R8: A beat with nonzero `rresp` (0 means OKAY) sets the sticky `resp_err` in the cycle after its edge, and `resp_err` clears on the edge that accepts the next command.
- R9: `done` is high for exactly one cycle, the cycle right after the edge that accepts the final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_beats | input | CNT_W | Total beats, at least 1 |
| cmd_size | input | 3 | Bytes per beat as a power of two |
| cmd_burst | input | 2 | Burst type passed to `arburst` |
| cmd_id | input | ID_W | Transaction ID and expected read ID |
| cmd_addr_dly | input | DLY_W | Cycles to wait before address issue |
| cmd_data_dly | input | DLY_W | Cycles to wait before raising `rready` |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | ADDR_W | Burst start address |
| arlen | output | 4 | Burst length minus one |
| arsize | output | 3 | Transfer size |
| arburst | output | 2 | Burst type |
| arid | output | ID_W | Read ID |
| arlock | output | 2 | Lock type, zero |
| arcache | output | 4 | Cache attributes, zero |
| arprot | output | 3 | Protection attributes, zero |
| arqos | output | 4 | Quality of service, zero |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | DATA_W | Read data |
| rid | input | ID_W | Read ID returned |
| rresp | input | 2 | Read response, 0 = OKAY |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | DATA_W | Output beat data |
| done | output | 1 | One-cycle pulse after the final beat |
| id_err | output | 1 | Sticky ID mismatch flag |
| resp_err | output | 1 | Sticky error response flag |

## Verification
Both delay counters load on the accepting edge. The bench numbers the cycles after that edge and expects the first `arvalid` in cycle A. It checks `rready` in every cycle against D, `out_ready` and the number of beats still owed. It evaluates each handshake at the negative edge and credits it to the rising edge that follows. The sticky flags are therefore expected one cycle after the offending beat's edge, and `done` exactly one cycle after the final beat's edge. Address bursts are compared as they are taken, against the burst index, the size and the remaining count.

// File: rtl/axrd_pkg.sv
package axrd_pkg;
  localparam int AXRD_LEN_W     = 4;
  localparam int AXRD_MAX_BEATS = 1 << AXRD_LEN_W;
  localparam int AXRD_SIZE_W    = 3;
  localparam int AXRD_BURST_W   = 2;
  localparam int AXRD_RESP_W    = 2;
  localparam int AXRD_LOCK_W    = 2;
  localparam int AXRD_CACHE_W   = 4;
  localparam int AXRD_PROT_W    = 3;
  localparam int AXRD_QOS_W     = 4;
  localparam logic [AXRD_RESP_W-1:0] AXRD_RESP_OKAY = 2'b00;
endpackage

// File: rtl/axrd_delay.sv
// Start-delay countdown: loads on a command, reports expiry when it reaches zero.
module axrd_delay #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= value;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/axrd_ar_issue.sv
// Address path: splits a command into bursts of at most the maximum burst length.
module axrd_ar_issue
  import axrd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 12,
  parameter int CNT_W  = 12,
  parameter int DLY_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [CNT_W-1:0]        beats,
  input  logic [AXRD_SIZE_W-1:0]  size,
  input  logic [AXRD_BURST_W-1:0] burst,
  input  logic [ID_W-1:0]         id,
  input  logic [DLY_W-1:0]        dly,
  input  logic                    arready,
  output logic                    arvalid,
  output logic [ADDR_W-1:0]       araddr,
  output logic [AXRD_LEN_W-1:0]   arlen,
  output logic [AXRD_SIZE_W-1:0]  arsize,
  output logic [AXRD_BURST_W-1:0] arburst,
  output logic [ID_W-1:0]         arid,
  output logic                    busy
);
  localparam logic [CNT_W-1:0] FULL_BEATS = CNT_W'(AXRD_MAX_BEATS);

  logic                    active_q;
  logic [ADDR_W-1:0]       addr_q;
  logic [CNT_W-1:0]        rem_q;
  logic [AXRD_SIZE_W-1:0]  size_q;
  logic [AXRD_BURST_W-1:0] burst_q;
  logic [ID_W-1:0]         id_q;
  logic                    dly_done;
  logic                    more;
  logic                    fire;
  logic [ADDR_W-1:0]       step;

  axrd_delay #(.W(DLY_W)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .value   (dly),
    .expired (dly_done)
  );

  assign more = (rem_q > FULL_BEATS);
  assign step = ADDR_W'(AXRD_MAX_BEATS) << size_q;
  assign fire = arvalid & arready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      rem_q    <= '0;
      size_q   <= '0;
      burst_q  <= '0;
      id_q     <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      addr_q   <= addr;
      rem_q    <= beats;
      size_q   <= size;
      burst_q  <= burst;
      id_q     <= id;
    end else if (fire) begin
      if (more) begin
        rem_q  <= rem_q - FULL_BEATS;
        addr_q <= addr_q + step;
      end else begin
        active_q <= 1'b0;
      end
    end
  end

  assign arvalid = active_q & dly_done;
  assign araddr  = addr_q;
  assign arlen   = more ? '1 : AXRD_LEN_W'(rem_q - CNT_W'(1));
  assign arsize  = size_q;
  assign arburst = burst_q;
  assign arid    = id_q;
  assign busy    = active_q;
endmodule

// File: rtl/axrd_r_collect.sv
// Data path: counts beats, checks ID and response, forwards data to the stream.
module axrd_r_collect
  import axrd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 12,
  parameter int CNT_W  = 12,
  parameter int DLY_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CNT_W-1:0]       beats,
  input  logic [ID_W-1:0]        id,
  input  logic [DLY_W-1:0]       dly,
  input  logic                   rvalid,
  input  logic [DATA_W-1:0]      rdata,
  input  logic [ID_W-1:0]        rid,
  input  logic [AXRD_RESP_W-1:0] rresp,
  output logic                   rready,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [DATA_W-1:0]      out_data,
  output logic                   done,
  output logic                   id_err,
  output logic                   resp_err,
  output logic                   busy
);
  logic             active_q;
  logic [CNT_W-1:0] rem_q;
  logic [ID_W-1:0]  id_q;
  logic             id_err_q;
  logic             resp_err_q;
  logic             done_q;
  logic             dly_done;
  logic             phase;
  logic             take;
  logic             last;

  axrd_delay #(.W(DLY_W)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .value   (dly),
    .expired (dly_done)
  );

  assign phase = active_q & dly_done;
  assign take  = rvalid & rready;
  assign last  = (rem_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      rem_q      <= '0;
      id_q       <= '0;
      id_err_q   <= 1'b0;
      resp_err_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= take & last;
      if (start) begin
        active_q   <= 1'b1;
        rem_q      <= beats;
        id_q       <= id;
        id_err_q   <= 1'b0;
        resp_err_q <= 1'b0;
      end else if (take) begin
        rem_q <= rem_q - 1'b1;
        if (last)                     active_q   <= 1'b0;
        if (rid != id_q)              id_err_q   <= 1'b1;
        if (rresp != AXRD_RESP_OKAY)  resp_err_q <= 1'b1;
      end
    end
  end

  assign rready    = phase & out_ready;
  assign out_valid = phase & rvalid;
  assign out_data  = rdata;
  assign done      = done_q;
  assign id_err    = id_err_q;
  assign resp_err  = resp_err_q;
  assign busy      = active_q;
endmodule

// File: rtl/axrd_master.sv
module axrd_master
  import axrd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 12,
  parameter int CNT_W  = 12,
  parameter int DLY_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [CNT_W-1:0]        cmd_beats,
  input  logic [AXRD_SIZE_W-1:0]  cmd_size,
  input  logic [AXRD_BURST_W-1:0] cmd_burst,
  input  logic [ID_W-1:0]         cmd_id,
  input  logic [DLY_W-1:0]        cmd_addr_dly,
  input  logic [DLY_W-1:0]        cmd_data_dly,
  output logic                    arvalid,
  input  logic                    arready,
  output logic [ADDR_W-1:0]       araddr,
  output logic [AXRD_LEN_W-1:0]   arlen,
  output logic [AXRD_SIZE_W-1:0]  arsize,
  output logic [AXRD_BURST_W-1:0] arburst,
  output logic [ID_W-1:0]         arid,
  output logic [AXRD_LOCK_W-1:0]  arlock,
  output logic [AXRD_CACHE_W-1:0] arcache,
  output logic [AXRD_PROT_W-1:0]  arprot,
  output logic [AXRD_QOS_W-1:0]   arqos,
  input  logic                    rvalid,
  output logic                    rready,
  input  logic [DATA_W-1:0]       rdata,
  input  logic [ID_W-1:0]         rid,
  input  logic [AXRD_RESP_W-1:0]  rresp,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DATA_W-1:0]       out_data,
  output logic                    done,
  output logic                    id_err,
  output logic                    resp_err
);
  logic start;
  logic a_busy;
  logic d_busy;

  assign cmd_ready = ~a_busy & ~d_busy;
  assign start     = cmd_valid & cmd_ready;

  axrd_ar_issue #(
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W),
    .CNT_W  (CNT_W),
    .DLY_W  (DLY_W)
  ) u_ar (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .addr    (cmd_addr),
    .beats   (cmd_beats),
    .size    (cmd_size),
    .burst   (cmd_burst),
    .id      (cmd_id),
    .dly     (cmd_addr_dly),
    .arready (arready),
    .arvalid (arvalid),
    .araddr  (araddr),
    .arlen   (arlen),
    .arsize  (arsize),
    .arburst (arburst),
    .arid    (arid),
    .busy    (a_busy)
  );

  axrd_r_collect #(
    .DATA_W (DATA_W),
    .ID_W   (ID_W),
    .CNT_W  (CNT_W),
    .DLY_W  (DLY_W)
  ) u_r (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .beats     (cmd_beats),
    .id        (cmd_id),
    .dly       (cmd_data_dly),
    .rvalid    (rvalid),
    .rdata     (rdata),
    .rid       (rid),
    .rresp     (rresp),
    .rready    (rready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .done      (done),
    .id_err    (id_err),
    .resp_err  (resp_err),
    .busy      (d_busy)
  );

  assign arlock  = '0;
  assign arcache = '0;
  assign arprot  = '0;
  assign arqos   = '0;
endmodule

// File: rtl/axrd_master_chk.sv
module axrd_master_chk #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ID_W-1:0]   cmd_id,
  input logic              arvalid,
  input logic              arready,
  input logic [ADDR_W-1:0] araddr,
  input logic [3:0]        arlen,
  input logic [2:0]        arsize,
  input logic [ID_W-1:0]   arid,
  input logic              rvalid,
  input logic              rready,
  input logic [ID_W-1:0]   rid,
  input logic [1:0]        rresp,
  input logic              out_valid,
  input logic              out_ready,
  input logic              done,
  input logic              id_err,
  input logic              resp_err
);
  logic [ID_W-1:0] exp_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      exp_id <= '0;
    else if (cmd_valid && cmd_ready) exp_id <= cmd_id;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!arvalid && !rready));

  assert_ar_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && !arready) |=> (arvalid && $stable(araddr) && $stable(arlen)
                               && $stable(arsize) && $stable(arid)));

  assert_rready_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rready |-> out_ready);

  assert_out_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rvalid);

  assert_id_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rready && (rid != exp_id)) |=> id_err);

  assert_flags_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!id_err && !resp_err));

  assert_resp_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rready && (rresp != 2'b00)) |=> resp_err);

  assert_done_after_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(rvalid && rready) && !rready));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind axrd_master axrd_master_chk #(
  .ADDR_W (ADDR_W),
  .ID_W   (ID_W)
) u_axrd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_id    (cmd_id),
  .arvalid   (arvalid),
  .arready   (arready),
  .araddr    (araddr),
  .arlen     (arlen),
  .arsize    (arsize),
  .arid      (arid),
  .rvalid    (rvalid),
  .rready    (rready),
  .rid       (rid),
  .rresp     (rresp),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .done      (done),
  .id_err    (id_err),
  .resp_err  (resp_err)
);

// File: tb/test_axrd_master.sv
module test_axrd_master;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int ID_W   = 12;
  localparam int CNT_W  = 12;
  localparam int DLY_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [CNT_W-1:0] cmd_beats = '0;
  logic [2:0] cmd_size = '0;
  logic [1:0] cmd_burst = '0;
  logic [ID_W-1:0] cmd_id = '0;
  logic [DLY_W-1:0] cmd_addr_dly = '0;
  logic [DLY_W-1:0] cmd_data_dly = '0;
  logic arvalid;
  logic arready = 1'b0;
  logic [ADDR_W-1:0] araddr;
  logic [3:0] arlen;
  logic [2:0] arsize;
  logic [1:0] arburst;
  logic [ID_W-1:0] arid;
  logic [1:0] arlock;
  logic [3:0] arcache;
  logic [2:0] arprot;
  logic [3:0] arqos;
  logic rvalid = 1'b0;
  logic rready;
  logic [DATA_W-1:0] rdata = '0;
  logic [ID_W-1:0] rid = '0;
  logic [1:0] rresp = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [DATA_W-1:0] out_data;
  logic done;
  logic id_err;
  logic resp_err;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  axrd_master #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .CNT_W(CNT_W), .DLY_W(DLY_W)
  ) i_axrd_master (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_beats(cmd_beats), .cmd_size(cmd_size), .cmd_burst(cmd_burst),
    .cmd_id(cmd_id), .cmd_addr_dly(cmd_addr_dly), .cmd_data_dly(cmd_data_dly),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
    .arsize(arsize), .arburst(arburst), .arid(arid), .arlock(arlock),
    .arcache(arcache), .arprot(arprot), .arqos(arqos),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rid(rid), .rresp(rresp),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .id_err(id_err), .resp_err(resp_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] beat_data(input logic [ADDR_W-1:0] a, input int j);
    return a * 3 + DATA_W'(j) * 32'h0100_0193;
  endfunction

  task automatic run(input logic [ADDR_W-1:0] a, input int n, input int sz, input int brst,
                     input int id, input int adly, input int ddly, input int pat,
                     input int bad_id_beat, input int bad_resp_beat);
    int t = 0;
    int bursts = 0;
    int avail = 0;
    int got = 0;
    int last_t = -10;
    int first_ar = -1;
    bit seen_done = 0;
    bit exp_ie = 0;
    bit exp_re = 0;
    bit prev_stall = 0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [3:0] prev_len = '0;
    int left;
    int exp_len;
    bit exp_rr;

    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready when idle", cmd_ready, 1);
    cmd_valid = 1'b1;
    cmd_addr = a;
    cmd_beats = CNT_W'(n);
    cmd_size = 3'(sz);
    cmd_burst = 2'(brst);
    cmd_id = ID_W'(id);
    cmd_addr_dly = DLY_W'(adly);
    cmd_data_dly = DLY_W'(ddly);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!seen_done && t < 4000) begin
      if (t == 0) begin
        chk(cmd_ready == 1'b0, "R1 busy after accept", cmd_ready, 0);
      end
      chk(id_err == exp_ie, "R7 id_err flag", id_err, exp_ie);
      chk(resp_err == exp_re, "R8 resp_err flag", resp_err, exp_re);
      if (prev_stall) begin
        chk(arvalid && araddr == prev_addr && arlen == prev_len, "R5 held burst",
            araddr, prev_addr);
      end
      if (arvalid && first_ar < 0) begin
        first_ar = t;
        chk(t == adly, "R4 address delay", t, adly);
      end
      arready = (pat == 0) ? 1'b1 : (t % 3 == 2);
      rvalid = (avail > 0) && ((pat == 0) || (t % 2 == 0));
      rdata = beat_data(a, got);
      rid = (got == bad_id_beat) ? ID_W'(id ^ 1) : ID_W'(id);
      rresp = (got == bad_resp_beat) ? 2'b10 : 2'b00;
      out_ready = (pat == 0) || (t % 4 != 3);
      #1;
      exp_rr = (got < n) && (t >= ddly) && out_ready;
      chk(rready == exp_rr, "R4 R6 rready timing", rready, exp_rr);
      if (done) begin
        seen_done = 1;
        chk(t == last_t + 1, "R9 done timing", t, last_t + 1);
      end
      prev_stall = arvalid && !arready;
      prev_addr = araddr;
      prev_len = arlen;
      if (arvalid && arready) begin
        left = n - 16 * bursts;
        exp_len = (left > 16) ? 15 : left - 1;
        chk(araddr == a + ADDR_W'(bursts * (16 << sz)), "R3 burst address",
            araddr, a + ADDR_W'(bursts * (16 << sz)));
        chk(arlen == 4'(exp_len), "R2 burst length", arlen, exp_len);
        chk(arsize == 3'(sz) && arburst == 2'(brst) && arid == ID_W'(id),
            "R3 burst fields", {arsize, arburst, arid}, {3'(sz), 2'(brst), ID_W'(id)});
        chk(arlock == 0 && arcache == 0 && arprot == 0 && arqos == 0, "R3 zero fields",
            {arlock, arcache, arprot, arqos}, 0);
        avail += int'(arlen) + 1;
        bursts++;
      end
      if (rvalid && rready) begin
        chk(out_valid && out_data == rdata, "R6 output beat", out_data, rdata);
        if (got == bad_id_beat) exp_ie = 1;
        if (got == bad_resp_beat) exp_re = 1;
        got++;
        avail--;
        last_t = t;
      end
      @(posedge clk);
      @(negedge clk);
      t++;
    end
    arready = 1'b0;
    rvalid = 1'b0;
    chk(seen_done, "R9 done seen", seen_done, 1);
    chk(got == n, "R6 beat count", got, n);
    chk(bursts == (n + 15) / 16, "R2 burst count", bursts, (n + 15) / 16);
    chk(id_err == exp_ie, "R7 sticky id_err at end", id_err, exp_ie);
    chk(resp_err == exp_re, "R8 sticky resp_err at end", resp_err, exp_re);
    chk(done == 1'b0, "R9 single pulse", done, 0);
    chk(cmd_ready == 1'b1, "R1 idle at end", cmd_ready, 1);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lens[9] = '{1, 2, 15, 16, 17, 31, 32, 33, 40};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !arvalid && !rready && !out_valid && !done && !id_err && !resp_err,
        "R1 reset state", {cmd_ready, arvalid, rready, out_valid, done, id_err, resp_err},
        7'b1000000);
    foreach (lens[li]) begin
      for (int sz = 0; sz <= 2; sz += 2) begin
        for (int d = 0; d < 3; d++) begin
          for (int pat = 0; pat < 2; pat++) begin
            run(32'h1000_0000 + ADDR_W'(li * 32'h400 + d * 32'h40), lens[li], sz, 1,
                'h5A0 + li, (d == 1) ? 2 : 0, (d == 1) ? 3 : ((d == 2) ? 5 : 0), pat,
                (pat == 1) ? lens[li] - 1 : -1, (d != 0) ? lens[li] / 2 : -1);
          end
        end
      end
    end
    run(32'h2000_0000, 20, 2, 2, 'h7FF, 0, 0, 0, 0, 19);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule